// File: doc/BRIEF.md
# Serial Octal Examine/Deposit Monitor

This block is a hardware command interpreter for a halted processor. It reads ASCII characters from a byte-wide serial receive stream and assembles octal numbers from the digits it receives. Single-character commands then open a memory word and print its contents, deposit a new value, or move to a neighbouring or computed location. Other commands start or resume the processor. Readout and echo leave on a byte-wide transmit stream that waits on `tx_ready_i`.

Memory is reached through a plain word port. The port takes byte addresses of `W`-bit words, and read data returns on the cycle after the request. A separate detector raises a halt request when a line-break condition appears on the serial input while the processor is running. The monitor accepts characters only while the processor is halted. A character that arrives while the monitor is still busy with an earlier one is dropped.

Top module: `octal_monitor`

## Requirements
- R1: After reset, `tx_valid_o`, `mem_req_o`, `start_o`, `proceed_o` and `halt_req_o` are low, and no word is open.
- R2: A received character 0x30..0x37 is echoed unchanged and enters the accumulator, which shifts left by 3 bits and keeps the low `W` bits. Any other byte, including 0x38 and 0x39, is not a digit.
- R3: '/' (0x2F) opens the word at the accumulated address, with bit 0 forced to 0. If no digits were typed, it reopens the current address. The word is printed as six octal digits, most significant first with the top digit holding bit 15 alone, followed by a space (0x20).
- R4: Carriage return (0x0D) closes the word and prints '@' (0x40). If digits were typed while the word was open, that value is written to the open address first. Otherwise nothing is written.
- R5: Line feed (0x0A) does the same optional write, then opens and prints the word at the current address + 2, modulo 2^W.
- R6: '^' (0x5E) does the same optional write, then opens and prints the word at the current address − 2, modulo 2^W.
- R7: '@' (0x40) does the same optional write, then opens the word whose address is the current contents, forced even. The current contents are the typed value if one was entered.
- R8: '_' (0x5F) does the same optional write, then opens the word at (current contents + current address) modulo 2^W, forced even.
- R9: 'G' (0x47) pulses `start_o` for exactly one cycle, with `start_addr_o` equal to the accumulated value forced even. 'P' (0x50) pulses `proceed_o` for one cycle. Both close any open word and print nothing.
- R10: Any other character prints '?' (0x3F), closes the word and clears the accumulator. LF, '^', '@' and '_' with no word open also print '?'.
- R11: While `cpu_run_i` is high, received characters are ignored. They cause no transmit, no memory request and no change to the accumulator.
- R12: `halt_req_o` rises one cycle after `rx_break_i` is seen high while `cpu_run_i` is high. It stays high until the cycle after `cpu_run_i` falls. A break while halted has no effect.
- R13: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` holds its value.
- R14: Every memory request carries an even address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received ASCII byte |
| rx_break_i | input | 1 | Line-break condition on the serial input |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit ASCII byte |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | W | Byte address, always even |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid the cycle after a read request |
| cpu_run_i | input | 1 | Processor is running |
| start_o | output | 1 | One-cycle start pulse |
| start_addr_o | output | W | Start address given with `start_o` |
| proceed_o | output | 1 | One-cycle resume pulse |
| halt_req_o | output | 1 | Halt request to the processor |

## Verification
The first echo byte or the '?' is offered on the cycle after the character is accepted. The first digit of an opened word appears three cycles after its command, or four cycles when a deposit comes first. `start_o` and `proceed_o` are high exactly one cycle after acceptance. `halt_req_o` follows `rx_break_i` and the fall of `cpu_run_i` by one cycle. The bench samples these pulse signals on the falling edge that directly follows the expected register update. For printed text, which depends on a throttled `tx_ready_i`, the bench collects every accepted byte and compares the whole string after a settle window longer than the longest print. Memory effects are read from the bench's own memory model once that window has closed.

// File: rtl/omon_pkg.sv
package omon_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_RQ, ST_RD, ST_TX} st_e;
  typedef enum logic [2:0] {A_NONE, A_NAV, A_CLOSE, A_ERR, A_GO, A_PRC} act_e;

  localparam logic [7:0] CH_SLASH = 8'h2F;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_UP    = 8'h5E;
  localparam logic [7:0] CH_AT    = 8'h40;
  localparam logic [7:0] CH_US    = 8'h5F;
  localparam logic [7:0] CH_G     = 8'h47;
  localparam logic [7:0] CH_P     = 8'h50;
  localparam logic [7:0] CH_Q     = 8'h3F;
  localparam logic [7:0] CH_SP    = 8'h20;
endpackage

// File: rtl/omon_acc.sv
module omon_acc #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         dig_vld_i,
  input  logic [2:0]   dig_i,
  output logic [W-1:0] val_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
      vld_o <= 1'b0;
    end else if (clr_i) begin
      val_o <= '0;
      vld_o <= 1'b0;
    end else if (dig_vld_i) begin
      val_o <= {val_o[W-4:0], dig_i};
      vld_o <= 1'b1;
    end
  end

  // R2
  acc_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_vld_i && !clr_i |=> vld_o && val_o[2:0] == $past(dig_i));
endmodule

// File: rtl/omon_tx.sv
module omon_tx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_word_i,
  input  logic [W-1:0] word_i,
  input  logic         load_char_i,
  input  logic [7:0]   char_i,
  input  logic         tx_ready_i,
  output logic         tx_valid_o,
  output logic [7:0]   tx_data_o,
  output logic         busy_o
);
  import omon_pkg::*;

  localparam int NDIG = (W + 2) / 3;
  localparam int PW   = NDIG * 3;
  localparam int CW   = $clog2(NDIG + 2);

  logic [PW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          word_q;
  logic [7:0]    ch_q;

  assign tx_valid_o = cnt_q != '0;
  assign busy_o     = tx_valid_o;

  always_comb begin
    if (!word_q)                tx_data_o = ch_q;
    else if (cnt_q == CW'(1))   tx_data_o = CH_SP;
    else                        tx_data_o = {5'b00110, sh_q[PW-1 -: 3]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_q <= 1'b0;
      ch_q   <= '0;
    end else if (load_word_i) begin
      sh_q   <= PW'(word_i);
      cnt_q  <= CW'(NDIG + 1);
      word_q <= 1'b1;
    end else if (load_char_i) begin
      ch_q   <= char_i;
      cnt_q  <= CW'(1);
      word_q <= 1'b0;
    end else if (tx_valid_o && tx_ready_i) begin
      cnt_q <= cnt_q - CW'(1);
      sh_q  <= sh_q << 3;
    end
  end

  // R13
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R13
  tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_word_i || load_char_i) |-> !busy_o);
endmodule

// File: rtl/omon_brk.sv
module omon_brk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic brk_i,
  output logic halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_o <= 1'b0;
    else         halt_o <= run_i & (halt_o | brk_i);
  end

  // R12
  halt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(brk_i) && $past(run_i));

  // R12
  halt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !halt_o);
endmodule

// File: rtl/octal_monitor.sv
module octal_monitor #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_valid_i,
  input  logic [7:0]   rx_data_i,
  input  logic         rx_break_i,
  output logic         tx_valid_o,
  output logic [7:0]   tx_data_o,
  input  logic         tx_ready_i,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         cpu_run_i,
  output logic         start_o,
  output logic [W-1:0] start_addr_o,
  output logic         proceed_o,
  output logic         halt_req_o
);
  import omon_pkg::*;

  localparam logic [W-1:0] STEP = W'(2);

  st_e          st_q;
  act_e         act;
  logic         open_q, pend_open_q;
  logic [W-1:0] cur_addr_q, cur_data_q, nxt_addr_q, wr_data_q;
  logic         start_q, proceed_q;
  logic [W-1:0] start_addr_q;

  logic         accept, is_dig, do_wr, wr_en;
  logic         acc_clr, acc_dig, acc_vld;
  logic [W-1:0] acc_val, cur_val, tgt, tgt_even;
  logic         ld_c, ld_w, tx_busy;
  logic [7:0]   c_char;

  omon_acc #(.W(W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i     (acc_clr),
    .dig_vld_i (acc_dig),
    .dig_i     (rx_data_i[2:0]),
    .val_o     (acc_val),
    .vld_o     (acc_vld)
  );

  omon_tx #(.W(W)) u_tx (
    .clk_i, .rst_ni,
    .load_word_i (ld_w),
    .word_i      (mem_rdata_i),
    .load_char_i (ld_c),
    .char_i      (c_char),
    .tx_ready_i,
    .tx_valid_o,
    .tx_data_o,
    .busy_o      (tx_busy)
  );

  omon_brk u_brk (
    .clk_i, .rst_ni,
    .run_i  (cpu_run_i),
    .brk_i  (rx_break_i),
    .halt_o (halt_req_o)
  );

  assign accept  = (st_q == ST_IDLE) && rx_valid_i && !cpu_run_i;
  assign is_dig  = rx_data_i[7:3] == 5'b00110;
  assign do_wr   = open_q && acc_vld;
  assign cur_val = acc_vld ? acc_val : cur_data_q;
  assign tgt_even = {tgt[W-1:1], 1'b0};

  always_comb begin
    acc_clr = 1'b0;
    acc_dig = 1'b0;
    ld_c    = 1'b0;
    c_char  = CH_Q;
    act     = A_NONE;
    tgt     = cur_addr_q;
    wr_en   = 1'b0;
    if (accept) begin
      if (is_dig) begin
        acc_dig = 1'b1;
        ld_c    = 1'b1;
        c_char  = rx_data_i;
      end else begin
        acc_clr = 1'b1;
        case (rx_data_i)
          CH_SLASH: begin
            act = A_NAV;
            tgt = acc_vld ? acc_val : cur_addr_q;
          end
          CH_CR: begin
            act   = A_CLOSE;
            wr_en = do_wr;
          end
          CH_LF: if (open_q) begin
            act = A_NAV; wr_en = do_wr; tgt = cur_addr_q + STEP;
          end else act = A_ERR;
          CH_UP: if (open_q) begin
            act = A_NAV; wr_en = do_wr; tgt = cur_addr_q - STEP;
          end else act = A_ERR;
          CH_AT: if (open_q) begin
            act = A_NAV; wr_en = do_wr; tgt = cur_val;
          end else act = A_ERR;
          CH_US: if (open_q) begin
            act = A_NAV; wr_en = do_wr; tgt = cur_val + cur_addr_q;
          end else act = A_ERR;
          CH_G:    act = A_GO;
          CH_P:    act = A_PRC;
          default: act = A_ERR;
        endcase
        if (act == A_ERR) begin
          ld_c = 1'b1; c_char = CH_Q;
        end else if (act == A_CLOSE && !wr_en) begin
          ld_c = 1'b1; c_char = CH_AT;
        end
      end
    end else if (st_q == ST_WR && !pend_open_q) begin
      ld_c   = 1'b1;
      c_char = CH_AT;
    end
  end

  assign ld_w        = st_q == ST_RD;
  assign mem_req_o   = (st_q == ST_WR) || (st_q == ST_RQ);
  assign mem_we_o    = st_q == ST_WR;
  assign mem_addr_o  = (st_q == ST_WR) ? cur_addr_q : nxt_addr_q;
  assign mem_wdata_o = wr_data_q;
  assign start_o      = start_q;
  assign start_addr_o = start_addr_q;
  assign proceed_o    = proceed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      open_q       <= 1'b0;
      pend_open_q  <= 1'b0;
      cur_addr_q   <= '0;
      cur_data_q   <= '0;
      nxt_addr_q   <= '0;
      wr_data_q    <= '0;
      start_q      <= 1'b0;
      proceed_q    <= 1'b0;
      start_addr_q <= '0;
    end else begin
      start_q   <= 1'b0;
      proceed_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          case (act)
            A_NAV: begin
              nxt_addr_q  <= tgt_even;
              wr_data_q   <= acc_val;
              pend_open_q <= 1'b1;
              st_q        <= wr_en ? ST_WR : ST_RQ;
            end
            A_CLOSE: begin
              wr_data_q   <= acc_val;
              pend_open_q <= 1'b0;
              open_q      <= 1'b0;
              st_q        <= wr_en ? ST_WR : ST_TX;
            end
            A_ERR: begin
              open_q <= 1'b0;
              st_q   <= ST_TX;
            end
            A_GO: begin
              start_q      <= 1'b1;
              start_addr_q <= {acc_val[W-1:1], 1'b0};
              open_q       <= 1'b0;
            end
            A_PRC: begin
              proceed_q <= 1'b1;
              open_q    <= 1'b0;
            end
            default: if (ld_c) st_q <= ST_TX;
          endcase
        end
        ST_WR: st_q <= pend_open_q ? ST_RQ : ST_TX;
        ST_RQ: st_q <= ST_RD;
        ST_RD: begin
          cur_data_q <= mem_rdata_i;
          cur_addr_q <= nxt_addr_q;
          open_q     <= 1'b1;
          st_q       <= ST_TX;
        end
        ST_TX: if (!tx_busy) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R14
  mem_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);

  // R4
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |=> !mem_we_o);

  // R9
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R9
  proceed_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proceed_o |=> !proceed_o);

  // R11
  run_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && cpu_run_i && st_q == ST_IDLE |=> st_q == ST_IDLE && !start_o && !proceed_o);
endmodule

// File: tb/sim_octal_monitor.sv
module sim_octal_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_break = 1'b0;
  logic tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic mem_req, mem_we;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata;
  logic cpu_run = 1'b0;
  logic start, proceed, halt_req;
  logic [W-1:0] start_addr;

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, wr_cnt = 0, odd_cnt = 0;
  int cyc = 0;
  bit done = 0;
  string got = "";
  logic [W-1:0] mem [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  octal_monitor #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .cpu_run_i(cpu_run), .start_o(start), .start_addr_o(start_addr),
    .proceed_o(proceed), .halt_req_o(halt_req)
  );

  assign tx_ready = (cyc % 3) != 2;

  function automatic int idx(logic [W-1:0] a);
    return int'(a[6:1]);
  endfunction

  function automatic string oct6(logic [W-1:0] w);
    return $sformatf("%06o ", w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= W'(i * 4093) ^ 16'o070707;
      mem_rdata <= '0;
      cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (mem_req) begin
        req_cnt <= req_cnt + 1;
        if (mem_addr[0]) odd_cnt <= odd_cnt + 1;
        if (mem_we) begin
          mem[idx(mem_addr)] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else mem_rdata <= mem[idx(mem_addr)];
      end
    end
  end

  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready) got = $sformatf("%s%c", got, tx_data);

  task automatic check(bit ok, string req, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic expect_tx(string exp, string req);
    check(got == exp, req, got, exp);
    got = "";
  endtask

  task automatic type_oct(logic [W-1:0] v);
    string s = $sformatf("%o", v);
    for (int i = 0; i < s.len(); i++) send(s[i]);
    expect_tx(s, "R2 echo");
  endtask

  task automatic open_at(logic [W-1:0] a);
    type_oct(a);
    send("/");
    expect_tx(oct6(mem[idx(a)]), "R3 open");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, c, v;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!tx_valid && !mem_req && !start && !proceed && !halt_req, "R1",
          $sformatf("%b%b%b%b%b", tx_valid, mem_req, start, proceed, halt_req), "00000");

    // R2/R3 echo and open, R4 close without deposit
    open_at(16'o170);
    w0 = wr_cnt;
    send(8'h0D);
    expect_tx("@", "R4 prompt");
    check(wr_cnt == w0, "R4 no write", $sformatf("%0d", wr_cnt), $sformatf("%0d", w0));

    // R3 odd address forced even, R5 sweep forward
    a = 16'o11;
    type_oct(a);
    send("/");
    a = 16'o10;
    expect_tx(oct6(mem[idx(a)]), "R3 even");
    for (int k = 0; k < 40; k++) begin
      send(8'h0A);
      a = a + 2;
      expect_tx(oct6(mem[idx(a)]), "R5 next");
    end
    // R6 sweep back
    for (int k = 0; k < 12; k++) begin
      send(8'h5E);
      a = a - 2;
      expect_tx(oct6(mem[idx(a)]), "R6 prev");
    end
    send(8'h0D);
    expect_tx("@", "R4 prompt");

    // R4 deposit on close
    open_at(16'o20);
    type_oct(16'o1234);
    send(8'h0D);
    expect_tx("@", "R4 prompt");
    check(mem[idx(16'o20)] == 16'o1234, "R4 deposit",
          $sformatf("%o", mem[idx(16'o20)]), "1234");

    // R5 deposit then next
    open_at(16'o30);
    type_oct(16'o77);
    send(8'h0A);
    expect_tx(oct6(mem[idx(16'o32)]), "R5 next after deposit");
    check(mem[idx(16'o30)] == 16'o77, "R5 deposit",
          $sformatf("%o", mem[idx(16'o30)]), "77");
    send(8'h0D); got = "";

    // R7 indirect on contents
    open_at(16'o40);
    c = mem[idx(16'o40)];
    send(8'h40);
    expect_tx(oct6(mem[idx({c[W-1:1], 1'b0})]), "R7 indirect");
    // R7 indirect on typed value
    type_oct(16'o105);
    a = {c[W-1:1], 1'b0};
    send(8'h40);
    expect_tx(oct6(mem[idx(16'o104)]), "R7 indirect typed");
    check(mem[idx(a)] == 16'o105, "R7 deposit", $sformatf("%o", mem[idx(a)]), "105");
    send(8'h0D); got = "";

    // R8 indexed
    open_at(16'o50);
    c = mem[idx(16'o50)];
    v = c + 16'o50;
    send(8'h5F);
    expect_tx(oct6(mem[idx({v[W-1:1], 1'b0})]), "R8 indexed");
    send(8'h0D); got = "";
    // R8 wrap with deposit
    open_at(16'o177776);
    type_oct(16'o4);
    send(8'h5F);
    expect_tx(oct6(mem[idx(16'o2)]), "R8 wrap");
    // R6 wrap below zero
    send(8'h5E);
    expect_tx(oct6(mem[idx(16'o0)]), "R6 back to 0");
    send(8'h5E);
    expect_tx(oct6(mem[idx(16'o177776)]), "R6 wrap");
    // R5 wrap above top
    send(8'h0A);
    expect_tx(oct6(mem[idx(16'o0)]), "R5 wrap");
    send(8'h0D); got = "";

    // R10 errors
    send("X");
    expect_tx("?", "R10 unknown");
    send(8'h0A);
    expect_tx("?", "R10 next when closed");
    send("8");
    expect_tx("?", "R10 digit 8");
    send("5");
    send("X");
    expect_tx("5?", "R10 echo then error");
    send("3");
    send("/");
    expect_tx({"3", oct6(mem[idx(16'o2)])}, "R10 accumulator cleared");
    send(8'h0D); got = "";

    // R9 start and proceed
    type_oct(16'o1001);
    @(negedge clk); rx_valid = 1'b1; rx_data = "G";
    @(negedge clk); rx_valid = 1'b0;
    check(start && start_addr == 16'o1000, "R9 start",
          $sformatf("%b %o", start, start_addr), "1 1000");
    @(negedge clk);
    check(!start, "R9 start width", $sformatf("%b", start), "0");
    @(negedge clk); rx_valid = 1'b1; rx_data = "P";
    @(negedge clk); rx_valid = 1'b0;
    check(proceed, "R9 proceed", $sformatf("%b", proceed), "1");
    @(negedge clk);
    check(!proceed, "R9 proceed width", $sformatf("%b", proceed), "0");
    repeat (SETTLE) @(negedge clk);
    expect_tx("", "R9 no output");

    // R11 ignored while running
    cpu_run = 1'b1;
    w0 = req_cnt;
    send("7");
    send("/");
    expect_tx("", "R11 no tx");
    check(req_cnt == w0, "R11 no mem", $sformatf("%0d", req_cnt), $sformatf("%0d", w0));
    cpu_run = 1'b0;
    send("/");
    expect_tx(oct6(mem[idx(16'o2)]), "R11 accumulator unchanged");
    send(8'h0D); got = "";

    // R12 halt request
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk);
    check(!halt_req, "R12 break while halted", $sformatf("%b", halt_req), "0");
    cpu_run = 1'b1;
    @(negedge clk);
    check(halt_req, "R12 rise", $sformatf("%b", halt_req), "1");
    rx_break = 1'b0;
    repeat (4) @(negedge clk);
    check(halt_req, "R12 hold", $sformatf("%b", halt_req), "1");
    cpu_run = 1'b0;
    @(negedge clk);
    check(!halt_req, "R12 drop", $sformatf("%b", halt_req), "0");

    // R13 throttled readout verified through full strings above; R14
    check(odd_cnt == 0, "R14 even addresses", $sformatf("%0d", odd_cnt), "0");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule